// File: doc/BRIEF.md
# Address table flush engine

This block removes entries from a switch address table on software request. A small register file holds a match filter (a VLAN id and a filtering-database id), a match mode and a type selector. Eleven ports each have a write-one-to-start request bit and a busy status bit. Ports 0 to 7 sit in one register and ports 8 to 10 in a second one. One further bit clears the whole table.

When a request is accepted, the engine sweeps the table through a simple read-modify-write port. The read is combinational and takes one slot per clock, in ascending address order. A slot is cleared to all zeros when it holds a valid unicast entry that passes the port, mode and type filters. Requests that arrive while a sweep runs are latched and served later. When several are waiting, a whole-table request goes first, then the ports in ascending order.

Table slot encoding (23 bits): bit 0 valid, bit 1 multicast, bit 2 static, bits 6:3 port, bits 18:7 VLAN id, bits 22:19 filtering-database id.

Top module: `fdb_purge_engine`

## Requirements
- R1: After reset every register reads 0 at register addresses 0 to 4, and no table write is issued while no sweep runs.
- R2: Writing 1 to bit p (p = 0..7) of register address 0 starts a flush of port p. Bit 8+p of that register reads 1 from the cycle after the write until the sweep ends. An engine that was idle takes exactly DEPTH+1 cycles for the job, visiting slot 0 up to slot DEPTH-1, one per clock. Request bits read back as 0.
- R3: Ports 8 to 10 use register address 1. A write of 1 to bit p-8 (bits 2:0) starts the flush, and bit p-5 (bits 5:3) is the busy bit.
- R4: Register address 2 holds the VLAN id in bits 11:0 and the filtering-database id in bits 15:12, and reads back as written.
- R5: Register address 3 holds the match mode in bits 1:0 and the type bit in bit 2. It reads back only those three bits; the others read 0.
- R6: Mode 0 clears only valid, non-multicast slots whose port field equals the flushed port. Every other slot keeps its content.
- R7: Mode 1 also requires the slot's VLAN id to equal the filter VLAN id. Mode 2 instead requires the slot's filtering-database id to equal the filter id. Mode 3 behaves as mode 0. The filter and mode are taken when the sweep starts.
- R8: Type 0 leaves static slots in place; type 1 clears matching static and dynamic slots alike.
- R9: Several waiting port requests are flushed one after another in ascending port order. Each job takes DEPTH+1 cycles, and each busy bit clears when its own port's sweep ends.
- R10: Requests written while a sweep runs are latched, including a repeat of the running port, and are served after it.
- R11: Writing 1 to bit 0 of register address 4 clears every valid slot (any port, multicast or static). That bit reads 1 until the sweep is done, DEPTH+1 cycles after an idle-time write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| tbl_addr | output | AW | Table slot address being visited |
| tbl_rdata | input | 23 | Slot content at tbl_addr (combinational read) |
| tbl_wr | output | 1 | Write strobe that clears the visited slot |
| tbl_wdata | output | 23 | Data written to the slot (all zeros) |

## Verification
A request written at clock edge E0 shows as busy at once after E0. The job starts at E1, and slot k is cleared at edge E(k+2). The busy bit clears after E(DEPTH+1), and each queued job adds another DEPTH+1 cycles. The bench drives and samples on the falling edge and keeps a free-running edge counter, so every busy-clear time is compared with an exact multiple of DEPTH+1 from the first write. Table contents are compared slot by slot after the busy bit falls, against a filter computed in the bench from the raw bit fields. This runs for every mode and type and several ports in both register groups.

// File: rtl/fdb_purge_pkg.sv
package fdb_purge_pkg;

  typedef struct packed {
    logic [3:0]  fid;
    logic [11:0] vid;
    logic [3:0]  port;
    logic        is_static;
    logic        is_mc;
    logic        valid;
  } slot_t;

  localparam int SLOT_W = $bits(slot_t);

  typedef enum logic [1:0] {
    MATCH_PORT = 2'd0,
    MATCH_VID  = 2'd1,
    MATCH_FID  = 2'd2,
    MATCH_RSVD = 2'd3
  } match_mode_e;

  typedef struct packed {
    logic        whole;
    logic [3:0]  port;
    match_mode_e mode;
    logic        incl_static;
    logic [11:0] vid;
    logic [3:0]  fid;
  } job_t;

  // Decide whether a slot is removed by a job.
  function automatic logic slot_hit(slot_t s, job_t j);
    logic key_ok;
    if (!s.valid) return 1'b0;
    if (j.whole) return 1'b1;
    if (s.is_mc || (s.port != j.port)) return 1'b0;
    if (s.is_static && !j.incl_static) return 1'b0;
    case (j.mode)
      MATCH_VID: key_ok = (s.vid == j.vid);
      MATCH_FID: key_ok = (s.fid == j.fid);
      default:   key_ok = 1'b1;
    endcase
    return key_ok;
  endfunction

endpackage

// File: rtl/fdb_purge_regs.sv
module fdb_purge_regs
  import fdb_purge_pkg::*;
#(
  parameter int LO_PORTS = 8,
  parameter int HI_PORTS = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr,
  input  logic [2:0]                   addr,
  input  logic [15:0]                  wdata,
  output logic [15:0]                  rdata,
  input  logic [LO_PORTS+HI_PORTS-1:0] take_oh,
  input  logic                         take_whole,
  input  logic [LO_PORTS+HI_PORTS-1:0] act_oh,
  input  logic                         act_whole,
  input  logic                         done,
  output logic [LO_PORTS+HI_PORTS-1:0] pending,
  output logic                         whole_pend,
  output logic [11:0]                  flt_vid,
  output logic [3:0]                   flt_fid,
  output match_mode_e                  flt_mode,
  output logic                         flt_static
);
  localparam int NP = LO_PORTS + HI_PORTS;

  logic [NP-1:0] set_bits;
  logic [NP-1:0] busy;
  logic          whole_busy;
  logic          whole_set;

  always_comb begin
    set_bits = '0;
    if (wr && addr == 3'd0) set_bits[LO_PORTS-1:0]  = wdata[LO_PORTS-1:0];
    if (wr && addr == 3'd1) set_bits[NP-1:LO_PORTS] = wdata[HI_PORTS-1:0];
  end

  assign whole_set = wr && (addr == 3'd4) && wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending    <= '0;
      whole_pend <= 1'b0;
      flt_vid    <= '0;
      flt_fid    <= '0;
      flt_mode   <= MATCH_PORT;
      flt_static <= 1'b0;
    end else begin
      pending    <= (pending & ~take_oh) | set_bits;
      whole_pend <= (whole_pend & ~take_whole) | whole_set;
      if (wr && addr == 3'd2) begin
        flt_vid <= wdata[11:0];
        flt_fid <= wdata[15:12];
      end
      if (wr && addr == 3'd3) begin
        flt_mode   <= match_mode_e'(wdata[1:0]);
        flt_static <= wdata[2];
      end
    end
  end

  assign busy       = pending | act_oh;
  assign whole_busy = whole_pend | act_whole;

  always_comb begin
    rdata = '0;
    case (addr)
      3'd0: rdata[2*LO_PORTS-1:LO_PORTS] = busy[LO_PORTS-1:0];
      3'd1: rdata[2*HI_PORTS-1:HI_PORTS] = busy[NP-1:LO_PORTS];
      3'd2: rdata = {flt_fid, flt_vid};
      3'd3: rdata = {13'd0, flt_static, flt_mode};
      3'd4: rdata = {15'd0, whole_busy};
      default: rdata = '0;
    endcase
  end

  for (genvar p = 0; p < NP; p++) begin : g_busy_chk
    // R2
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy[p] && !(done && act_oh[p]) |=> busy[p]);
  end

endmodule

// File: rtl/fdb_purge_arbiter.sv
module fdb_purge_arbiter #(
  parameter int NP = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NP-1:0] pending,
  input  logic          whole_pend,
  input  logic          idle,
  output logic          start,
  output logic          grant_whole,
  output logic [NP-1:0] grant_oh,
  output logic [3:0]    grant_idx
);

  function automatic logic [3:0] first_set(logic [NP-1:0] v);
    for (int i = NP - 1; i >= 0; i--)
      if (v[i]) first_set = 4'(i);
    if (v == '0) first_set = 4'd0;
  endfunction

  assign start       = idle && (whole_pend || (pending != '0));
  assign grant_whole = whole_pend;
  assign grant_oh    = whole_pend ? '0 : (pending & (~pending + 1'b1));
  assign grant_idx   = first_set(pending);

  // R9
  grant_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> ($onehot0(grant_oh) && ((grant_oh & ~pending) == '0)));

  // R9
  lowest_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !grant_whole |-> (((grant_oh - 1'b1) & pending) == '0) && grant_oh[grant_idx]);

endmodule

// File: rtl/fdb_purge_sweep.sv
module fdb_purge_sweep
  import fdb_purge_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  job_t              job_in,
  output logic              active,
  output job_t              job,
  output logic              done,
  output logic [AW-1:0]     tbl_addr,
  input  logic [SLOT_W-1:0] tbl_rdata,
  output logic              tbl_wr,
  output logic [SLOT_W-1:0] tbl_wdata
);
  logic [AW-1:0] addr;
  slot_t         slot;

  assign slot = slot_t'(tbl_rdata);
  assign done = active && (addr == AW'(DEPTH - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      addr   <= '0;
      job    <= '0;
    end else if (!active) begin
      if (start) begin
        active <= 1'b1;
        addr   <= '0;
        job    <= job_in;
      end
    end else begin
      active <= !done;
      addr   <= done ? '0 : addr + 1'b1;
    end
  end

  assign tbl_addr  = addr;
  assign tbl_wr    = active && slot_hit(slot, job);
  assign tbl_wdata = '0;

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !tbl_wr);

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active && !done |=> active && (tbl_addr == $past(tbl_addr) + 1'b1));

  // R6
  clear_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_wr |-> slot.valid && (job.whole || (!slot.is_mc && slot.port == job.port)));

endmodule

// File: rtl/fdb_purge_engine.sv
module fdb_purge_engine
  import fdb_purge_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int LO_PORTS = 8,
  parameter int HI_PORTS = 3,
  parameter int AW       = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  output logic [AW-1:0]     tbl_addr,
  input  logic [SLOT_W-1:0] tbl_rdata,
  output logic              tbl_wr,
  output logic [SLOT_W-1:0] tbl_wdata
);
  localparam int NP = LO_PORTS + HI_PORTS;

  logic [NP-1:0] pending, grant_oh, take_oh, act_oh;
  logic          whole_pend, grant_whole, start, active, done;
  logic [3:0]    grant_idx;
  logic [11:0]   flt_vid;
  logic [3:0]    flt_fid;
  match_mode_e   flt_mode;
  logic          flt_static;
  job_t          job_in, job;

  assign take_oh = start ? grant_oh : '0;
  assign act_oh  = (active && !job.whole) ? ({{(NP-1){1'b0}}, 1'b1} << job.port) : '0;

  always_comb begin
    job_in             = '0;
    job_in.whole       = grant_whole;
    job_in.port        = grant_idx;
    job_in.mode        = flt_mode;
    job_in.incl_static = flt_static;
    job_in.vid         = flt_vid;
    job_in.fid         = flt_fid;
  end

  fdb_purge_regs #(.LO_PORTS(LO_PORTS), .HI_PORTS(HI_PORTS)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (reg_wr),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .rdata      (reg_rdata),
    .take_oh    (take_oh),
    .take_whole (start && grant_whole),
    .act_oh     (act_oh),
    .act_whole  (active && job.whole),
    .done       (done),
    .pending    (pending),
    .whole_pend (whole_pend),
    .flt_vid    (flt_vid),
    .flt_fid    (flt_fid),
    .flt_mode   (flt_mode),
    .flt_static (flt_static)
  );

  fdb_purge_arbiter #(.NP(NP)) u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .pending     (pending),
    .whole_pend  (whole_pend),
    .idle        (!active),
    .start       (start),
    .grant_whole (grant_whole),
    .grant_oh    (grant_oh),
    .grant_idx   (grant_idx)
  );

  fdb_purge_sweep #(.DEPTH(DEPTH), .AW(AW)) u_sweep (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .job_in    (job_in),
    .active    (active),
    .job       (job),
    .done      (done),
    .tbl_addr  (tbl_addr),
    .tbl_rdata (tbl_rdata),
    .tbl_wr    (tbl_wr),
    .tbl_wdata (tbl_wdata)
  );

endmodule

// File: tb/fdb_purge_engine_bench.sv
module fdb_purge_engine_bench;
  localparam int D  = 16;
  localparam int AW = 4;
  localparam int SW = 23;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [15:0]   reg_wdata = '0;
  logic [15:0]   reg_rdata;
  logic [AW-1:0] tbl_addr;
  logic [SW-1:0] tbl_rdata;
  logic          tbl_wr;
  logic [SW-1:0] tbl_wdata;

  logic [SW-1:0] mem [D];
  logic [SW-1:0] snap [D];
  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) if (tbl_wr) mem[tbl_addr] <= tbl_wdata;
  assign tbl_rdata = mem[tbl_addr];

  fdb_purge_engine #(.DEPTH(D)) u_fdb_purge_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tbl_addr(tbl_addr),
    .tbl_rdata(tbl_rdata), .tbl_wr(tbl_wr), .tbl_wdata(tbl_wdata));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // Wait until the given register bit reads 0; count falling edges.
  task automatic wait_low(logic [2:0] a, int b, output int cnt);
    logic [15:0] v;
    cnt = 0;
    rd(a, v);
    while (v[b] && cnt < 1000) begin
      @(negedge clk);
      cnt++;
      rd(a, v);
    end
  endtask

  function automatic logic [SW-1:0] gen(int i, int p);
    logic [SW-1:0] e;
    e = '0;
    e[0]     = (i % 8) != 7;
    e[1]     = (i % 6) == 5;
    e[2]     = (i % 4) >= 2;
    e[6:3]   = ((i / 4) % 2 == 0) ? 4'(p) : 4'(p ^ 1);
    e[18:7]  = 12'(12'h100 + (i % 3));
    e[22:19] = 4'(i % 4);
    return e;
  endfunction

  task automatic fill(int p);
    @(negedge clk);
    for (int i = 0; i < D; i++) begin
      mem[i]  = gen(i, p);
      snap[i] = mem[i];
    end
  endtask

  function automatic logic [SW-1:0] expect_slot(logic [SW-1:0] r, int p,
      int mode, int ty, logic [11:0] tv, logic [3:0] tf);
    bit key;
    key = (mode == 1) ? (r[18:7] == tv) : (mode == 2) ? (r[22:19] == tf) : 1'b1;
    if (r[0] && !r[1] && r[6:3] == 4'(p) && (ty == 1 || !r[2]) && key) return '0;
    return r;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int cnt;
    int c0, t_a, t_b, t_c;
    for (int i = 0; i < D; i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      chk("R1 reset readback", 32'(v), 32'h0);
    end
    chk("R1 no table write when idle", 32'(tbl_wr), 32'h0);

    // R4, R5 register readback
    wr(3'd2, 16'hA123);
    rd(3'd2, v); chk("R4 filter readback", 32'(v), 32'hA123);
    wr(3'd3, 16'hFFFF);
    rd(3'd3, v); chk("R5 control readback", 32'(v), 32'h0007);

    // R6 R7 R8 with R2/R3 timing: every mode and type, several ports
    for (int r = 0; r < 8; r++) begin
      int p, mode, ty;
      p = (r * 3 + 10) % 11;
      mode = r / 2;
      ty = r % 2;
      fill(p);
      wr(3'd2, 16'h2101);
      wr(3'd3, 16'(ty * 4 + mode));
      if (p < 8) begin
        wr(3'd0, 16'(1 << p));
        wait_low(3'd0, 8 + p, cnt);
        chk("R2 busy duration low group", 32'(cnt), 32'(D + 1));
      end else begin
        wr(3'd1, 16'(1 << (p - 8)));
        wait_low(3'd1, 3 + (p - 8), cnt);
        chk("R3 busy duration ext group", 32'(cnt), 32'(D + 1));
      end
      for (int i = 0; i < D; i++)
        chk(mode == 0 ? "R6 port filter slot" : (ty == 0 ? "R7 key filter slot, R8 type 0"
            : "R7 key filter slot, R8 type 1"),
            32'(mem[i]), 32'(expect_slot(snap[i], p, mode, ty, 12'h101, 4'h2)));
    end
    rd(3'd0, v); chk("R2 request bits read 0", 32'(v[7:0]), 32'h0);

    // R9 ascending order, busy clears per own sweep
    fill(1);
    wr(3'd3, 16'h0004);
    wr(3'd0, 16'h0022);
    c0 = cyc;
    wr(3'd1, 16'h0001);
    t_a = 0; t_b = 0; t_c = 0;
    for (int k = 0; k < 4 * (D + 1); k++) begin
      rd(3'd0, v);
      if (!v[9]  && t_a == 0) t_a = cyc;
      if (!v[13] && t_b == 0) t_b = cyc;
      rd(3'd1, v);
      if (!v[3]  && t_c == 0) t_c = cyc;
      @(negedge clk);
    end
    chk("R9 port 1 done", 32'(t_a - c0), 32'(D + 1));
    chk("R9 port 5 done", 32'(t_b - c0), 32'(2 * (D + 1)));
    chk("R9 port 8 done", 32'(t_c - c0), 32'(3 * (D + 1)));

    // R10 requests during a sweep are latched
    wr(3'd0, 16'h0010);
    c0 = cyc;
    repeat (3) @(negedge clk);
    wr(3'd0, 16'h0011);
    t_a = 0; t_b = 0;
    for (int k = 0; k < 4 * (D + 1); k++) begin
      rd(3'd0, v);
      if (!v[8]  && t_a == 0) t_a = cyc;
      if (!v[12] && t_b == 0) t_b = cyc;
      @(negedge clk);
    end
    chk("R10 queued port 0 done", 32'(t_a - c0), 32'(2 * (D + 1)));
    chk("R10 repeated port 4 done", 32'(t_b - c0), 32'(3 * (D + 1)));

    // R11 whole-table flush
    fill(3);
    wr(3'd4, 16'h0001);
    wait_low(3'd4, 0, cnt);
    chk("R11 whole flush duration", 32'(cnt), 32'(D + 1));
    for (int i = 0; i < D; i++)
      chk("R11 slot cleared", 32'(mem[i] & 23'h1), 32'h0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule